// File: doc/BRIEF.md
# Instruction Fetch Stage with Control-Flow Stall

This block is the front stage of a three-stage, in-order 32-bit pipeline. Each time it fetches, it presents a byte address to an instruction memory with an asynchronous read. It assembles the four bytes returned for that address and the three that follow into one instruction word. That word goes to the decode stage with its own address and a valid flag, and the program counter then moves on by one instruction.

When decode recognises a jump, call or return, it raises a branch flag. The fetch stage then places a bubble in the decode slot and waits. It fetches again only once the multi-cycle execute stage reports that it is done. No instruction from the wrong path ever reaches decode. Execute may load a new program counter at any time. A load made in the same cycle as done is used for the next fetch at once. Decoding and execution themselves lie outside this block.

Top module: `fetch_stage`

## Requirements
- R1: The instruction word is big-endian. Byte lane k of `imem_rdata_i` (bits 8k+7:8k), which holds the byte at address A+k, is placed in bits 31-8k down to 24-8k of `dec_instr_o`. The byte at A therefore lands in bits 31:24.
- R2: In a fetch cycle with fetch address A, the next edge sets `dec_valid_o` to 1, `dec_instr_o` to the word at A and `dec_pc_o` to A. The program counter becomes A+4.
- R3: A cycle with `branch_i` high fetches nothing, even when `dec_ready_i` is low. At its edge `dec_valid_o` goes to 0 and the stage enters the waiting state. The request has then been consumed.
- R4: In the waiting state, every cycle with `ex_done_i` low fetches nothing and keeps `dec_valid_o` at 0. A cycle with `ex_done_i` high leaves the waiting state, and in that same cycle it fetches if `dec_ready_i` is high.
- R5: Outside the waiting state, a cycle with `dec_ready_i` low and `branch_i` low fetches nothing. `dec_valid_o`, `dec_instr_o` and `dec_pc_o` keep their values.
- R6: During reset and after it, the program counter is 0, `dec_valid_o` is 0 and the stage is not waiting, so the first fetch uses address 0.
- R7: While `ex_pc_load_i` is high, `imem_addr_o` is the loaded address in that same cycle. A fetch in that cycle uses the loaded address, and when nothing is fetched the program counter keeps the loaded address.
- R8: Every fetch address is a multiple of 4 within a 24-bit space. The two low bits of a loaded address are cleared, and incrementing past 0xFFFFFC wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 24 | Byte address of the current fetch |
| imem_rdata_i | input | 32 | Bytes at imem_addr_o+k on lane k |
| dec_ready_i | input | 1 | Decode has consumed its current word |
| branch_i | input | 1 | Decode found a control-transfer instruction |
| ex_done_i | input | 1 | Execute has finished its current instruction |
| ex_pc_load_i | input | 1 | Execute loads a new program counter |
| ex_pc_i | input | 24 | Program counter value to load |
| dec_valid_o | output | 1 | Word to decode is valid |
| dec_instr_o | output | 32 | Instruction word to decode |
| dec_pc_o | output | 24 | Address of the instruction word |

## Verification
The bench builds the block with its default parameters: a 24-bit address space, 4-byte instructions and 8-bit bytes. With a 24-bit space, one direct load of an address close to the top makes the counter wrap to zero within a few cycles. The random phase mixes several things in the same cycles: branches, decode back-pressure, done pulses during the waiting state, and loads of misaligned targets. This covers the cases that overlap, such as a branch under back-pressure and a load in the cycle of done.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic {
    FS_RUN  = 1'b0,
    FS_WAIT = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/fetch_pc_gen.sv
module fetch_pc_gen #(
  parameter int ADDR_W      = 24,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_pc_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFS_W = $clog2(INSTR_BYTES);

  logic [ADDR_W-1:0] pc_q, pc_d, load_aligned;

  assign load_aligned = {load_pc_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  // a load in this cycle redirects the current fetch
  assign addr_o = load_i ? load_aligned : pc_q;
  assign pc_d   = advance_i ? addr_o + ADDR_W'(INSTR_BYTES) : addr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> pc_q == $past(addr_o) + ADDR_W'(INSTR_BYTES));
endmodule

// File: rtl/fetch_word_pack.sv
module fetch_word_pack #(
  parameter int BYTE_W      = 8,
  parameter int INSTR_BYTES = 4,
  localparam int WORD_W     = BYTE_W * INSTR_BYTES
) (
  input  logic [WORD_W-1:0] lanes_i,
  output logic [WORD_W-1:0] word_o
);
  // lane 0 (lowest address) goes to the most significant byte
  for (genvar k = 0; k < INSTR_BYTES; k++) begin : g_lane
    assign word_o[(INSTR_BYTES-1-k)*BYTE_W +: BYTE_W] = lanes_i[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic branch_i,
  input  logic ex_done_i,
  input  logic dec_ready_i,
  output logic fetch_go_o,
  output logic kill_o,
  output logic waiting_o
);
  fetch_state_e state_q, state_d;

  assign waiting_o  = (state_q == FS_WAIT);
  assign kill_o     = branch_i;
  assign fetch_go_o = !branch_i && (!waiting_o || ex_done_i) && dec_ready_i;

  always_comb begin
    state_d = state_q;
    if (branch_i)                  state_d = FS_WAIT;
    else if (waiting_o && ex_done_i) state_d = FS_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FS_RUN;
    else         state_q <= state_d;
  end

  // R3
  branch_waits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i |=> waiting_o);
  // R4
  wait_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o && !ex_done_i |-> !fetch_go_o);
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage #(
  parameter int  ADDR_W      = 24,
  parameter int  INSTR_BYTES = 4,
  parameter int  BYTE_W      = 8,
  localparam int INSTR_W     = BYTE_W * INSTR_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_rdata_i,
  input  logic               dec_ready_i,
  input  logic               branch_i,
  input  logic               ex_done_i,
  input  logic               ex_pc_load_i,
  input  logic [ADDR_W-1:0]  ex_pc_i,
  output logic               dec_valid_o,
  output logic [INSTR_W-1:0] dec_instr_o,
  output logic [ADDR_W-1:0]  dec_pc_o
);
  logic               fetch_go, kill, waiting;
  logic [INSTR_W-1:0] word;
  logic               valid_q;
  logic [INSTR_W-1:0] instr_q;
  logic [ADDR_W-1:0]  dpc_q;

  fetch_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .branch_i    (branch_i),
    .ex_done_i   (ex_done_i),
    .dec_ready_i (dec_ready_i),
    .fetch_go_o  (fetch_go),
    .kill_o      (kill),
    .waiting_o   (waiting)
  );

  fetch_pc_gen #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ex_pc_load_i),
    .load_pc_i (ex_pc_i),
    .advance_i (fetch_go),
    .addr_o    (imem_addr_o)
  );

  fetch_word_pack #(.BYTE_W(BYTE_W), .INSTR_BYTES(INSTR_BYTES)) u_pack (
    .lanes_i (imem_rdata_i),
    .word_o  (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      instr_q <= '0;
      dpc_q   <= '0;
    end else begin
      if (kill) begin
        valid_q <= 1'b0;
      end else if (fetch_go) begin
        valid_q <= 1'b1;
        instr_q <= word;
        dpc_q   <= imem_addr_o;
      end else if (waiting) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign dec_valid_o = valid_q;
  assign dec_instr_o = instr_q;
  assign dec_pc_o    = dpc_q;

  // R2
  fetch_delivers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_go |=> dec_valid_o && dec_pc_o == $past(imem_addr_o));
  // R3
  bubble_after_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i |=> !dec_valid_o);
  // R5
  hold_on_backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branch_i && !dec_ready_i && !waiting |=>
      $stable(dec_valid_o) && $stable(dec_instr_o) && $stable(dec_pc_o));
  // R4
  wait_keeps_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting && !ex_done_i |=> !dec_valid_o);
endmodule

// File: tb/fetch_stage_bench.sv
module fetch_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int WD_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic          dec_ready = 1'b0, branch = 1'b0, ex_done = 1'b0, ex_load = 1'b0;
  logic [AW-1:0] ex_pc = '0;
  logic          dec_valid;
  logic [31:0]   dec_instr;
  logic [AW-1:0] dec_pc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_stage u_fetch_stage (
    .clk_i(clk), .rst_ni(rst_n), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dec_ready_i(dec_ready), .branch_i(branch), .ex_done_i(ex_done),
    .ex_pc_load_i(ex_load), .ex_pc_i(ex_pc),
    .dec_valid_o(dec_valid), .dec_instr_o(dec_instr), .dec_pc_o(dec_pc));

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[3:0], a[23:20]} ^ 8'h5A;
  endfunction

  // R1: lane k carries the byte at addr+k
  always_comb begin
    for (int k = 0; k < 4; k++) imem_rdata[k*8 +: 8] = mem_byte(imem_addr + AW'(k));
  end

  function automatic logic [31:0] exp_word(logic [AW-1:0] a);
    return {mem_byte(a), mem_byte(a + 24'd1), mem_byte(a + 24'd2), mem_byte(a + 24'd3)};
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic ld, logic [AW-1:0] lpc, logic [AW-1:0] pc);
    return ld ? {lpc[AW-1:2], 2'b00} : pc;
  endfunction

  // reference state from the requirements
  logic          m_wait, m_valid;
  logic [AW-1:0] m_pc, m_dpc;
  logic [31:0]   m_instr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait <= 1'b0; m_valid <= 1'b0; m_pc <= '0; m_dpc <= '0; m_instr <= '0;
    end else begin
      logic [AW-1:0] a;
      a = exp_addr(ex_load, ex_pc, m_pc);
      if (branch) begin
        m_valid <= 1'b0; m_wait <= 1'b1; m_pc <= a;
      end else begin
        if (m_wait && ex_done) m_wait <= 1'b0;
        if ((!m_wait || ex_done) && dec_ready) begin
          m_valid <= 1'b1; m_instr <= exp_word(a); m_dpc <= a; m_pc <= a + 24'd4;
        end else m_pc <= a;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R7/R8 fetch address", 32'(imem_addr), 32'(exp_addr(ex_load, ex_pc, m_pc)));
    check("R8 address alignment", 32'(imem_addr[1:0]), 32'd0);
    check("R2/R3/R4/R5 decode valid", 32'(dec_valid), 32'(m_valid));
    if (m_valid) begin
      check("R1/R2 instruction word", dec_instr, m_instr);
      check("R2 instruction address", 32'(dec_pc), 32'(m_dpc));
    end
  endtask

  task automatic step(logic rdy, logic br, logic dn, logic ld, logic [AW-1:0] pc);
    dec_ready = rdy; branch = br; ex_done = dn; ex_load = ld; ex_pc = pc;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6 valid in reset", 32'(dec_valid), 32'd0);
    check("R6 pc in reset", 32'(imem_addr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 first address", 32'(imem_addr), 32'd0);
    // R1: explicit first word at address 0
    step(1, 0, 0, 0, '0);
    check("R1 word at 0", dec_instr, {mem_byte(0), mem_byte(1), mem_byte(2), mem_byte(3)});
    check("R2 next address", 32'(imem_addr), 32'd4);
    // R3: branch under back-pressure still bubbles and waits
    step(0, 1, 0, 0, '0);
    check("R3 bubble", 32'(dec_valid), 32'd0);
    // R4: stay idle while execute busy
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    check("R4 idle in wait", 32'(dec_valid), 32'd0);
    // R7: load with done in same cycle, misaligned target
    step(1, 0, 1, 1, 24'h00123B);
    check("R7 loaded fetch pc", 32'(dec_pc), 32'h00123B & 32'hFFFFFC);
    // R5: back-pressure holds outputs
    step(0, 0, 0, 0, '0);
    check("R5 held pc", 32'(dec_pc), 32'h001238);
    // R8: wrap at top of space
    step(1, 0, 0, 1, 24'hFFFFFE);
    check("R8 top fetch", 32'(dec_pc), 32'hFFFFFC);
    step(1, 0, 0, 0, '0);
    check("R8 wrap", 32'(dec_pc), 32'h0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic rdy, br, dn, ld;
      rdy = ($urandom % 10) < 8;
      br  = ($urandom % 20) == 0;
      dn  = ($urandom % 10) < 3;
      ld  = ($urandom % 10) == 0;
      step(rdy, br, dn, ld, AW'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule